// File: doc/BRIEF.md
# Reordering DRAM Request Scheduler

This block sits between an upstream request arbiter and a DRAM controller. It keeps a small pool of pending memory requests. Whenever the controller signals that it can take a request, the block picks one from the pool by a fixed cascade of rules. Each request carries a direction (read or write), a priority, a bank and a row.

The block models the state of each bank. It records which row is open and how many cycles have passed since the bank was last activated, and it remembers the direction of the last request it issued. Issuing a request whose row differs from the open row of its bank counts as an activation. That row becomes the open row of the bank, so requests to the old row turn into misses.

The choice is made again in every cycle, over the whole pool, so a request admitted in the same cycle competes at once. Command timing on the DRAM bus and data movement are handled downstream.

Top module: `rq_sched`

## Requirements
- R1: `req_ready_o` is high exactly when fewer than DEPTH requests are pending. Every accepted request is issued exactly once, and no request is accepted while the pool is full.
- R2: Among eligible pending requests, one with the highest priority is issued.
- R3: Among eligible requests of equal top priority, one whose row equals the currently open row of its bank (a hit) wins over misses.
- R4: A bank activated within the last T_RC cycles is not eligible: no request to it, hit or miss, is issued until T_RC clock edges have passed since the activating issue. Banks start out eligible and closed.
- R5: Among requests still tied after R2 to R4, one whose direction (`wr` = 1 for write, 0 for read) equals that of the last issued request wins. The last direction is read after reset.
- R6: Any tie left after R5 goes to the request that arrived earliest.
- R7: Issuing a miss opens the issued row in its bank. Later requests to the bank's previous row are then treated as misses.
- R8: `iss_valid_o` is high exactly when at least one pending request is eligible. The issue fields describe the chosen request, and a request offered but not taken stays offered in the next cycle.
- R9: After reset the pool is empty: `iss_valid_o` is low and `req_ready_o` is high.
- R10: With rows opened beforehand in banks 1, 2 and 3, the seven-request pool below issues in the order R5, R6, R1, R7, R3, R4, R2 when the controller pauses until eligibility returns:
  - R1: RD, priority 7, new row, bank 0
  - R2: WR, priority 4, open row, bank 1
  - R3: RD, priority 4, bank 0, the same row as R1
  - R4: RD, priority 4, new row, bank 1
  - R5: WR, priority 7, open row, bank 2
  - R6: WR, priority 7, new row, bank 1
  - R7: WR, priority 4, open row, bank 3

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Upstream request present |
| req_ready_o | output | 1 | A pool slot is free |
| req_wr_i | input | 1 | Request direction, 1 = write |
| req_prio_i | input | PRIO_W | Request priority, larger wins |
| req_bank_i | input | $clog2(BANKS) | Target bank |
| req_row_i | input | ROW_W | Target row |
| iss_valid_o | output | 1 | An eligible request is offered |
| iss_ready_i | input | 1 | Controller takes the offered request |
| iss_wr_o | output | 1 | Direction of the offered request |
| iss_prio_o | output | PRIO_W | Priority of the offered request |
| iss_bank_o | output | $clog2(BANKS) | Bank of the offered request |
| iss_row_o | output | ROW_W | Row of the offered request |

## Verification
The bench builds the block with DEPTH 8, four banks, a 3-bit priority, 4-bit rows and a T_RC of only 6 cycles. The short activation wait lets a single directed sequence show both blocking and release, and lets the worked ordering run end to end in a few dozen cycles. With only four banks and four row values, random traffic produces frequent hits, row closures, full-pool back-pressure and cases where every pending bank is still waiting. These cases are compared each cycle against a behavioural queue model.

// File: rtl/rq_sched_pkg.sv
`timescale 1ns/1ps
package rq_sched_pkg;
  typedef enum logic {
    REQ_RD = 1'b0,
    REQ_WR = 1'b1
  } req_dir_e;
endpackage

// File: rtl/rq_pool.sv
`timescale 1ns/1ps
// Arrival-ordered store: slot 0 is the oldest, removal compacts the tail.
module rq_pool #(
  parameter int DEPTH = 8,
  parameter int EW    = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  logic [EW-1:0]              push_ent_i,
  input  logic                       pop_i,
  input  logic [IW-1:0]              pop_idx_i,
  output logic [DEPTH-1:0][EW-1:0]   ent_o,
  output logic [CW-1:0]              cnt_o
);
  logic [DEPTH-1:0][EW-1:0] ent_q, ent_d;
  logic [DEPTH:0][EW-1:0]   ext;
  logic [CW-1:0]            cnt_q, wr_pos;

  assign ext    = {{EW{1'b0}}, ent_q};
  assign wr_pos = cnt_q - CW'(pop_i);

  always_comb begin
    ent_d = ent_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (pop_i && (IW'(i) >= pop_idx_i)) ent_d[i] = ext[i+1];
      if (push_i && (wr_pos == CW'(i)))   ent_d[i] = push_ent_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_q <= '0;
      cnt_q <= '0;
    end else begin
      ent_q <= ent_d;
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign ent_o = ent_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/rq_bank_track.sv
`timescale 1ns/1ps
module rq_bank_track #(
  parameter int BANKS   = 8,
  parameter int ROW_W   = 14,
  parameter int T_RC    = 39,
  localparam int BANK_W = $clog2(BANKS),
  localparam int AW     = $clog2(T_RC + 1)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          act_i,
  input  logic [BANK_W-1:0]             act_bank_i,
  input  logic [ROW_W-1:0]              act_row_i,
  output logic [BANKS-1:0]              open_v_o,
  output logic [BANKS-1:0][ROW_W-1:0]   open_row_o,
  output logic [BANKS-1:0]              rdy_o
);
  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    logic             open_q;
    logic [ROW_W-1:0] row_q;
    logic [AW-1:0]    age_q;
    logic             hit_me;

    assign hit_me = act_i && (act_bank_i == BANK_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_q <= 1'b0;
        row_q  <= '0;
        age_q  <= AW'(T_RC);
      end else if (hit_me) begin
        open_q <= 1'b1;
        row_q  <= act_row_i;
        age_q  <= '0;
      end else if (age_q != AW'(T_RC)) begin
        age_q  <= age_q + AW'(1);
      end
    end

    assign open_v_o[g]   = open_q;
    assign open_row_o[g] = row_q;
    assign rdy_o[g]      = (age_q == AW'(T_RC));
  end
endmodule

// File: rtl/rq_pick.sv
`timescale 1ns/1ps
// Key per slot = {priority, hit, same direction}; strict compare keeps the oldest.
module rq_pick #(
  parameter int DEPTH   = 8,
  parameter int BANKS   = 8,
  parameter int PRIO_W  = 3,
  parameter int ROW_W   = 14,
  localparam int BANK_W = $clog2(BANKS),
  localparam int EW     = 1 + PRIO_W + BANK_W + ROW_W,
  localparam int KW     = PRIO_W + 2,
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int IW     = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0][EW-1:0]     ent_i,
  input  logic [CW-1:0]                cnt_i,
  input  logic [BANKS-1:0]             open_v_i,
  input  logic [BANKS-1:0][ROW_W-1:0]  open_row_i,
  input  logic [BANKS-1:0]             bank_rdy_i,
  input  logic                         last_wr_i,
  output logic                         valid_o,
  output logic [IW-1:0]                idx_o,
  output logic                         hit_o
);
  logic [DEPTH-1:0]         elig, hit;
  logic [DEPTH-1:0][KW-1:0] key;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic              wr;
    logic [PRIO_W-1:0] pr;
    logic [BANK_W-1:0] bk;
    logic [ROW_W-1:0]  rw;
    assign {wr, pr, bk, rw} = ent_i[g];
    assign elig[g] = (CW'(g) < cnt_i) && bank_rdy_i[bk];
    assign hit[g]  = open_v_i[bk] && (open_row_i[bk] == rw);
    assign key[g]  = {pr, hit[g], wr == last_wr_i};
  end

  always_comb begin
    logic          found;
    logic [KW-1:0] best;
    found = 1'b0;
    best  = '0;
    idx_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (elig[i] && (!found || key[i] > best)) begin
        found = 1'b1;
        best  = key[i];
        idx_o = IW'(i);
      end
    end
    valid_o = found;
  end

  assign hit_o = hit[idx_o];
endmodule

// File: rtl/rq_sched.sv
`timescale 1ns/1ps
module rq_sched
  import rq_sched_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int BANKS   = 8,
  parameter int PRIO_W  = 3,
  parameter int ROW_W   = 14,
  parameter int T_RC    = 39,
  localparam int BANK_W = $clog2(BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_wr_i,
  input  logic [PRIO_W-1:0] req_prio_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  output logic              iss_valid_o,
  input  logic              iss_ready_i,
  output logic              iss_wr_o,
  output logic [PRIO_W-1:0] iss_prio_o,
  output logic [BANK_W-1:0] iss_bank_o,
  output logic [ROW_W-1:0]  iss_row_o
);
  localparam int EW = 1 + PRIO_W + BANK_W + ROW_W;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);

  logic [DEPTH-1:0][EW-1:0]    ent;
  logic [CW-1:0]               cnt;
  logic [BANKS-1:0]            open_v, bank_rdy;
  logic [BANKS-1:0][ROW_W-1:0] open_row;
  logic                        pick_vld, pick_hit, push, fire;
  logic [IW-1:0]               pick_idx;
  req_dir_e                    last_dir_q;

  assign req_ready_o = (cnt < CW'(DEPTH));
  assign push        = req_valid_i && req_ready_o;
  assign fire        = iss_valid_o && iss_ready_i;

  rq_pool #(.DEPTH(DEPTH), .EW(EW)) u_pool (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .push_ent_i ({req_wr_i, req_prio_i, req_bank_i, req_row_i}),
    .pop_i      (fire),
    .pop_idx_i  (pick_idx),
    .ent_o      (ent),
    .cnt_o      (cnt)
  );

  rq_bank_track #(.BANKS(BANKS), .ROW_W(ROW_W), .T_RC(T_RC)) u_banks (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (fire && !pick_hit),
    .act_bank_i (iss_bank_o),
    .act_row_i  (iss_row_o),
    .open_v_o   (open_v),
    .open_row_o (open_row),
    .rdy_o      (bank_rdy)
  );

  rq_pick #(.DEPTH(DEPTH), .BANKS(BANKS), .PRIO_W(PRIO_W), .ROW_W(ROW_W)) u_pick (
    .ent_i      (ent),
    .cnt_i      (cnt),
    .open_v_i   (open_v),
    .open_row_i (open_row),
    .bank_rdy_i (bank_rdy),
    .last_wr_i  (last_dir_q == REQ_WR),
    .valid_o    (pick_vld),
    .idx_o      (pick_idx),
    .hit_o      (pick_hit)
  );

  assign iss_valid_o = pick_vld;
  assign {iss_wr_o, iss_prio_o, iss_bank_o, iss_row_o} = ent[pick_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   last_dir_q <= REQ_RD;
    else if (fire) last_dir_q <= iss_wr_o ? REQ_WR : REQ_RD;
  end
endmodule

// File: rtl/rq_sched_chk.sv
`timescale 1ns/1ps
module rq_sched_chk #(
  parameter int DEPTH   = 8,
  parameter int BANKS   = 8,
  parameter int ROW_W   = 14,
  parameter int T_RC    = 39,
  localparam int BANK_W = $clog2(BANKS),
  localparam int AW     = $clog2(T_RC + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              iss_valid_o,
  input logic              iss_ready_i,
  input logic [BANK_W-1:0] iss_bank_o,
  input logic [ROW_W-1:0]  iss_row_o
);
  logic                        fire;
  int                          occ_q;
  logic [BANKS-1:0]            sh_open;
  logic [BANKS-1:0][ROW_W-1:0] sh_row;
  logic [BANKS-1:0][AW-1:0]    sh_age;

  assign fire = iss_valid_o && iss_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q   <= 0;
      sh_open <= '0;
      sh_row  <= '0;
      for (int b = 0; b < BANKS; b++) sh_age[b] <= AW'(T_RC);
    end else begin
      occ_q <= occ_q + ((req_valid_i && req_ready_o) ? 1 : 0) - (fire ? 1 : 0);
      for (int b = 0; b < BANKS; b++) begin
        if (fire && iss_bank_o == BANK_W'(b) && (!sh_open[b] || sh_row[b] != iss_row_o)) begin
          sh_open[b] <= 1'b1;
          sh_row[b]  <= iss_row_o;
          sh_age[b]  <= '0;
        end else if (sh_age[b] != AW'(T_RC)) begin
          sh_age[b]  <= sh_age[b] + AW'(1);
        end
      end
    end
  end

  // R1
  ready_tracks_occupancy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o == (occ_q < DEPTH));

  // R8
  idle_when_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q == 0) |-> !iss_valid_o);

  // R8
  offer_persists_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_valid_o && !iss_ready_i) |=> iss_valid_o);

  // R4
  bank_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |-> (sh_age[iss_bank_o] == AW'(T_RC)));
endmodule

bind rq_sched rq_sched_chk #(.DEPTH(DEPTH), .BANKS(BANKS), .ROW_W(ROW_W), .T_RC(T_RC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .iss_valid_o (iss_valid_o),
  .iss_ready_i (iss_ready_i),
  .iss_bank_o  (iss_bank_o),
  .iss_row_o   (iss_row_o)
);

// File: tb/rq_sched_tb_top.sv
`timescale 1ns/1ps
module rq_sched_tb_top;
  localparam int DEPTH  = 8;
  localparam int BANKS  = 4;
  localparam int PRIO_W = 3;
  localparam int ROW_W  = 4;
  localparam int T_RC   = 6;
  localparam int BANK_W = $clog2(BANKS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              req_valid = 1'b0, req_wr = 1'b0;
  logic [PRIO_W-1:0] req_prio = '0;
  logic [BANK_W-1:0] req_bank = '0;
  logic [ROW_W-1:0]  req_row = '0;
  logic              iss_ready = 1'b0;
  logic              req_ready_o, iss_valid_o, iss_wr_o;
  logic [PRIO_W-1:0] iss_prio_o;
  logic [BANK_W-1:0] iss_bank_o;
  logic [ROW_W-1:0]  iss_row_o;

  rq_sched #(.DEPTH(DEPTH), .BANKS(BANKS), .PRIO_W(PRIO_W), .ROW_W(ROW_W), .T_RC(T_RC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready_o), .req_wr_i(req_wr),
    .req_prio_i(req_prio), .req_bank_i(req_bank), .req_row_i(req_row),
    .iss_valid_o(iss_valid_o), .iss_ready_i(iss_ready), .iss_wr_o(iss_wr_o),
    .iss_prio_o(iss_prio_o), .iss_bank_o(iss_bank_o), .iss_row_o(iss_row_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model
  int q_wr[$], q_prio[$], q_bank[$], q_row[$];
  bit m_open_v[BANKS];
  int m_open_row[BANKS];
  int m_act[BANKS];
  int m_last_wr = 0;
  int cyc = 0;
  int lg[$];
  int tot_acc = 0, tot_iss = 0;

  function automatic int pack(int wr, int prio, int bank, int row);
    return (wr << (PRIO_W + BANK_W + ROW_W)) | (prio << (BANK_W + ROW_W)) | (bank << ROW_W) | row;
  endfunction

  function automatic int dut_pack();
    return pack(int'(iss_wr_o), int'(iss_prio_o), int'(iss_bank_o), int'(iss_row_o));
  endfunction

  function automatic int m_pick();
    int best = -1;
    int bkey = -1;
    for (int i = 0; i < q_wr.size(); i++) begin
      int b = q_bank[i];
      bit rdy = (cyc - m_act[b]) >= T_RC;
      bit hit = m_open_v[b] && (m_open_row[b] == q_row[i]);
      int k = q_prio[i] * 4 + (hit ? 2 : 0) + ((q_wr[i] == m_last_wr) ? 1 : 0);
      if (rdy && k > bkey) begin
        best = i;
        bkey = k;
      end
    end
    return best;
  endfunction

  task automatic chk(bit ok, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic cycle();
    int idx;
    bit fire_e, acc_e;
    #1;
    idx = m_pick();
    chk(req_ready_o == (q_wr.size() < DEPTH), "R1 ready vs occupancy", int'(req_ready_o), int'(q_wr.size() < DEPTH));
    chk(iss_valid_o == (idx >= 0), "R8 offer valid", int'(iss_valid_o), int'(idx >= 0));
    if (idx >= 0 && iss_valid_o)
      chk(dut_pack() == pack(q_wr[idx], q_prio[idx], q_bank[idx], q_row[idx]),
          "R2/R3/R4/R5/R6 chosen request", dut_pack(), pack(q_wr[idx], q_prio[idx], q_bank[idx], q_row[idx]));
    fire_e = (idx >= 0) && iss_ready;
    acc_e  = req_valid && (q_wr.size() < DEPTH);
    if (iss_valid_o && iss_ready) begin
      lg.push_back(dut_pack());
      tot_iss++;
    end
    if (req_valid && req_ready_o) tot_acc++;
    @(posedge clk);
    cyc++;
    if (fire_e) begin
      int b = q_bank[idx];
      if (!(m_open_v[b] && m_open_row[b] == q_row[idx])) begin
        m_open_v[b] = 1;
        m_open_row[b] = q_row[idx];
        m_act[b] = cyc;
      end
      m_last_wr = q_wr[idx];
      q_wr.delete(idx); q_prio.delete(idx); q_bank.delete(idx); q_row.delete(idx);
    end
    if (acc_e) begin
      q_wr.push_back(int'(req_wr)); q_prio.push_back(int'(req_prio));
      q_bank.push_back(int'(req_bank)); q_row.push_back(int'(req_row));
    end
    @(negedge clk);
  endtask

  task automatic idle(int n);
    req_valid = 1'b0;
    repeat (n) cycle();
  endtask

  task automatic push(int wr, int prio, int bank, int row);
    req_valid = 1'b1;
    req_wr = wr[0];
    req_prio = PRIO_W'(prio);
    req_bank = BANK_W'(bank);
    req_row = ROW_W'(row);
    cycle();
    req_valid = 1'b0;
  endtask

  task automatic run_until(int n);
    for (int k = 0; k < 200 && lg.size() < n; k++) cycle();
  endtask

  task automatic exp_at(int pos, int wr, int prio, int bank, int row, string what);
    int e = pack(wr, prio, bank, row);
    int a = (pos < lg.size()) ? lg[pos] : -1;
    chk(a == e, what, a, e);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #750000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired: actual 1 expected 0");
      summary();
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < BANKS; b++) begin
      m_open_v[b] = 0;
      m_open_row[b] = 0;
      m_act[b] = -1000;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9 reset state
    chk(iss_valid_o == 1'b0, "R9 no offer after reset", int'(iss_valid_o), 0);
    chk(req_ready_o == 1'b1, "R9 ready after reset", int'(req_ready_o), 1);
    @(negedge clk);

    // R10 worked ordering: open bank1 row2, bank2 row3, bank3 row4
    iss_ready = 1'b1;
    push(0, 0, 1, 2); push(0, 0, 2, 3); push(0, 0, 3, 4);
    idle(T_RC + 3);
    iss_ready = 1'b0;
    push(0, 7, 0, 1);  // R1
    push(1, 4, 1, 2);  // R2
    push(0, 4, 0, 1);  // R3
    push(0, 4, 1, 6);  // R4
    push(1, 7, 2, 3);  // R5
    push(1, 7, 1, 5);  // R6
    push(1, 4, 3, 4);  // R7
    lg.delete();
    iss_ready = 1'b1;
    run_until(4);
    iss_ready = 1'b0;
    // R4: remaining requests all target freshly activated banks
    chk(iss_valid_o == 1'b0, "R4 fresh banks blocked", int'(iss_valid_o), 0);
    idle(T_RC + 2);
    iss_ready = 1'b1;
    run_until(7);
    exp_at(0, 1, 7, 2, 3, "R10/R3 first is top-priority hit");
    exp_at(1, 1, 7, 1, 5, "R10/R5 same direction next");
    exp_at(2, 0, 7, 0, 1, "R10/R2 priority before lower");
    exp_at(3, 1, 4, 3, 4, "R10/R4 only unblocked bank");
    exp_at(4, 0, 4, 0, 1, "R10/R3 hit on newly opened row");
    exp_at(5, 0, 4, 1, 6, "R10/R5 read follows read");
    exp_at(6, 1, 4, 1, 2, "R10/R7 closed row issued last");

    // R7 row closure
    idle(T_RC + 2);
    push(0, 3, 0, 7);
    run_until(8);
    iss_ready = 1'b0;
    idle(T_RC + 2);
    lg.delete();
    push(0, 3, 0, 1);
    push(1, 3, 0, 7);
    iss_ready = 1'b1;
    run_until(2);
    exp_at(0, 1, 3, 0, 7, "R7/R3 row7 hit beats old row");
    exp_at(1, 0, 3, 0, 1, "R7 old row issued as miss");

    // R6 arrival order and R1 full pool
    idle(T_RC + 2);
    iss_ready = 1'b0;
    lg.delete();
    push(0, 2, 3, 9); push(0, 2, 1, 10); push(0, 2, 0, 11); push(0, 2, 2, 12);
    for (int b = 0; b < BANKS; b++) push(0, 2, b, 13);
    chk(req_ready_o == 1'b0, "R1 full pool not ready", int'(req_ready_o), 0);
    req_valid = 1'b1; req_wr = 1'b0; req_prio = 3'd2; req_bank = '0; req_row = 4'd14;
    repeat (3) cycle();
    req_valid = 1'b0;
    iss_ready = 1'b1;
    run_until(8);
    idle(20);
    chk(lg.size() == 8, "R1 no extra accepted while full", lg.size(), 8);
    exp_at(0, 0, 2, 3, 9, "R6 oldest first");
    exp_at(1, 0, 2, 1, 10, "R6 second oldest");
    exp_at(2, 0, 2, 0, 11, "R6 third oldest");
    exp_at(3, 0, 2, 2, 12, "R6 fourth oldest");

    // random traffic
    for (int k = 0; k < 3000; k++) begin
      req_valid = ($urandom_range(0, 9) < 6);
      req_wr    = $urandom_range(0, 1) == 1;
      req_prio  = PRIO_W'($urandom_range(0, 7));
      req_bank  = BANK_W'($urandom_range(0, BANKS - 1));
      req_row   = ROW_W'($urandom_range(0, 3));
      iss_ready = ($urandom_range(0, 9) < 7);
      cycle();
    end
    req_valid = 1'b0;
    iss_ready = 1'b1;
    idle(300);
    chk(tot_acc == tot_iss, "R1 every accepted request issued once", tot_iss, tot_acc);
    chk(iss_valid_o == 1'b0, "R8 idle when drained", int'(iss_valid_o), 0);
    chk(req_ready_o == 1'b1, "R1 ready when drained", int'(req_ready_o), 1);

    done = 1;
    summary();
    $finish;
  end
endmodule